// File: doc/BRIEF.md
# Cipher Chaining-Value Context Guard

This block holds the 128-bit chaining value (initialization vector) that a block-cipher engine uses in CBC mode. It also decides when the host may touch that value. The host reaches the value through a small register port as two 64-bit halves. The engine side gives a start pulse that opens a message and a finish pulse that closes it. On finish, the engine hands back the last ciphertext block. The block stores that block as the new chaining value and raises a done indication.

Some host accesses are illegal. A write during a message, or a write while CBC is not selected, sets a sticky context-error flag, and the stored value is left untouched. A read of the value before done sets a separate sticky early-read flag, and the read returns zeros. After done, the host may read both halves to save context. It may write them back before restarting, so an interrupted message can continue. Both flags live in a status word and are cleared by writing ones to them.

Top module: `iv_ctx_guard`

## Requirements
- R1: After reset, the stored value, both error flags, busy, done and the read data are all zero.
- R2: Address 0 maps to the low half, value bits 63:0 (bytes 1–8). Address 1 maps to the high half, bits 127:64 (bytes 9–16). A write while idle or done with CBC selected shows on `iv_value` after the next clock edge.
- R3: A value write while a message is running sets the context-error flag (status bit 0) and leaves the stored value unchanged.
- R4: A value write while `cbc_sel` is low sets the context-error flag and leaves the stored value unchanged.
- R5: A start pulse is accepted only when CBC is selected, both halves have been loaded since reset (or a message has finished), and no message is running. A refused start leaves busy low.
- R6: A finish pulse during a message stores `eng_iv_final` as the new value, drops busy and raises done, all on the same edge.
- R7: A value read while done returns the addressed half on `host_rdata` one cycle later.
- R8: A value read while done is low returns zero one cycle later and sets the early-read flag (status bit 1).
- R9: Both flags stay set until the host writes a one to their bit at address 2. A write to address 2 changes no other state. A status read returns the flags in bits 1:0.
- R10: An accepted start clears done, so value reads are early again until the next finish.
- R11: A finish pulse while no message is running is ignored: the value and done do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | 0 low half, 1 high half, 2 status |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Registered host read data |
| cbc_sel | input | 1 | CBC mode selected |
| eng_start | input | 1 | Engine begins a message |
| eng_finish | input | 1 | Engine ends a message |
| eng_iv_final | input | 128 | Final chaining value from the engine |
| iv_value | output | 128 | Stored chaining value for the datapath |
| msg_busy | output | 1 | Message in progress |
| msg_done | output | 1 | Last message completed |
| err_ctx | output | 1 | Sticky context-error flag |
| err_early | output | 1 | Sticky early-read flag |

## Verification
Every result is registered once, so each one is due on the first rising edge after the strobe. This covers value writes, flag updates, phase changes on start and finish, and read data. The bench drives each strobe on a falling edge and removes it on the next falling edge. It samples outputs at that same falling edge, half a cycle after the edge that produced them. Refused accesses are checked by observing `iv_value`, busy and done at that point, before any further stimulus.

// File: rtl/iv_ctx_pkg.sv
package iv_ctx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  localparam int STAT_CTX_BIT   = 0;
  localparam int STAT_EARLY_BIT = 1;
endpackage

// File: rtl/iv_half_regs.sv
module iv_half_regs #(
  parameter int HALF_W     = 64,
  parameter int NUM_HALVES = 2,
  localparam int IV_W      = HALF_W * NUM_HALVES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_HALVES-1:0] wr_en,
  input  logic [HALF_W-1:0]     wdata,
  input  logic                  load_all,
  input  logic [IV_W-1:0]       load_data,
  output logic [IV_W-1:0]       iv_q,
  output logic                  iv_full
);
  logic [NUM_HALVES-1:0] loaded_q;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [HALF_W-1:0] half_d;
    logic              half_en;
    logic              ld_d;

    always_comb begin
      half_en = load_all | wr_en[h];
      half_d  = load_all ? load_data[h*HALF_W +: HALF_W] : wdata;
      ld_d    = loaded_q[h] | load_all | wr_en[h];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        iv_q[h*HALF_W +: HALF_W] <= '0;
        loaded_q[h]              <= 1'b0;
      end else begin
        if (half_en) iv_q[h*HALF_W +: HALF_W] <= half_d;
        loaded_q[h] <= ld_d;
      end
    end
  end

  assign iv_full = &loaded_q;

  p_engine_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_all |=> (iv_q == $past(load_data)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_all && wr_en == '0) |=> $stable(iv_q));
endmodule

// File: rtl/iv_phase_ctrl.sv
module iv_phase_ctrl
  import iv_ctx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cbc_sel,
  input  logic iv_full,
  input  logic eng_start,
  input  logic eng_finish,
  output logic busy,
  output logic done,
  output logic finish_ok
);
  phase_e phase_q, phase_d;
  logic   start_ok;

  always_comb begin
    start_ok  = eng_start && cbc_sel && iv_full && (phase_q != PH_RUN);
    finish_ok = eng_finish && (phase_q == PH_RUN);
    phase_d   = phase_q;
    if (start_ok)       phase_d = PH_RUN;
    else if (finish_ok) phase_d = PH_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign busy = (phase_q == PH_RUN);
  assign done = (phase_q == PH_DONE);

  p_start_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(eng_start && cbc_sel && iv_full)) |=> !busy);

  p_finish_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_finish) |=> (done && !busy));

  p_start_clears_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done);

  p_stray_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !eng_start) |=> $stable(done));
endmodule

// File: rtl/iv_err_flags.sv
module iv_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ctx,
  input  logic set_early,
  input  logic clr_ctx,
  input  logic clr_early,
  output logic ctx_q,
  output logic early_q
);
  logic ctx_d, early_d;

  always_comb begin
    ctx_d   = set_ctx   | (ctx_q   & ~clr_ctx);
    early_d = set_early | (early_q & ~clr_early);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q   <= 1'b0;
      early_q <= 1'b0;
    end else begin
      ctx_q   <= ctx_d;
      early_q <= early_d;
    end
  end

  p_ctx_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_q && !clr_ctx) |=> ctx_q);

  p_early_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (early_q && !clr_early) |=> early_q);
endmodule

// File: rtl/iv_ctx_guard.sv
module iv_ctx_guard
  import iv_ctx_pkg::*;
#(
  parameter int  HALF_W     = 64,
  parameter int  NUM_HALVES = 2,
  localparam int IV_W       = HALF_W * NUM_HALVES,
  localparam int ADDR_W     = $clog2(NUM_HALVES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HALF_W-1:0] host_wdata,
  output logic [HALF_W-1:0] host_rdata,
  input  logic              cbc_sel,
  input  logic              eng_start,
  input  logic              eng_finish,
  input  logic [IV_W-1:0]   eng_iv_final,
  output logic [IV_W-1:0]   iv_value,
  output logic              msg_busy,
  output logic              msg_done,
  output logic              err_ctx,
  output logic              err_early
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic                  hit_iv, hit_stat;
  logic                  wr_legal, set_ctx, set_early, clr_ctx, clr_early;
  logic                  rd_stat, rd_iv;
  logic [NUM_HALVES-1:0] wr_en;
  logic [HALF_W-1:0]     rd_half, rdata_d;
  logic                  iv_full, finish_ok;

  always_comb begin
    hit_iv    = int'(host_addr) < NUM_HALVES;
    hit_stat  = int'(host_addr) == NUM_HALVES;
    wr_legal  = host_wr && hit_iv && !msg_busy && cbc_sel;
    set_ctx   = host_wr && hit_iv && !wr_legal;
    clr_ctx   = host_wr && hit_stat && host_wdata[STAT_CTX_BIT];
    clr_early = host_wr && hit_stat && host_wdata[STAT_EARLY_BIT];
    rd_iv     = host_rd && hit_iv;
    rd_stat   = host_rd && hit_stat;
    set_early = rd_iv && !msg_done;
    wr_en     = '0;
    rd_half   = '0;
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (int'(host_addr) == h) begin
        wr_en[h] = wr_legal;
        rd_half  = iv_value[h*HALF_W +: HALF_W];
      end
    end
    rdata_d = '0;
    if (rd_stat) begin
      rdata_d[STAT_CTX_BIT]   = err_ctx;
      rdata_d[STAT_EARLY_BIT] = err_early;
    end else if (rd_iv && msg_done) begin
      rdata_d = rd_half;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     host_rdata <= '0;
    else if (host_rd) host_rdata <= rdata_d;
  end

  iv_half_regs #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_en),
    .wdata     (host_wdata),
    .load_all  (finish_ok),
    .load_data (eng_iv_final),
    .iv_q      (iv_value),
    .iv_full   (iv_full)
  );

  iv_phase_ctrl u_phase (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cbc_sel    (cbc_sel),
    .iv_full    (iv_full),
    .eng_start  (eng_start),
    .eng_finish (eng_finish),
    .busy       (msg_busy),
    .done       (msg_done),
    .finish_ok  (finish_ok)
  );

  iv_err_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .set_ctx   (set_ctx),
    .set_early (set_early),
    .clr_ctx   (clr_ctx),
    .clr_early (clr_early),
    .ctx_q     (err_ctx),
    .early_q   (err_early)
  );

  p_busy_write_hold_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_wr && hit_iv && msg_busy && !eng_finish) |=> ($stable(iv_value) && err_ctx));

  p_nocbc_write_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_wr && hit_iv && !cbc_sel) |=> err_ctx);

  p_early_zero_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_rd && hit_iv && !msg_done) |=> (host_rdata == '0 && err_early));

  p_phase_excl_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(msg_busy && msg_done));
endmodule

// File: tb/test_iv_ctx_guard.sv
module test_iv_ctx_guard;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         host_wr, host_rd, cbc_sel, eng_start, eng_finish;
  logic [1:0]   host_addr;
  logic [63:0]  host_wdata, host_rdata;
  logic [127:0] eng_iv_final, iv_value;
  logic         msg_busy, msg_done, err_ctx, err_early;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  iv_ctx_guard i_iv_ctx_guard (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cbc_sel(cbc_sel), .eng_start(eng_start), .eng_finish(eng_finish),
    .eng_iv_final(eng_iv_final), .iv_value(iv_value), .msg_busy(msg_busy),
    .msg_done(msg_done), .err_ctx(err_ctx), .err_early(err_early)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic start_msg();
    @(negedge clk); eng_start = 1'b1;
    @(negedge clk); eng_start = 1'b0;
  endtask

  task automatic finish_msg(input logic [127:0] v);
    @(negedge clk); eng_finish = 1'b1; eng_iv_final = v;
    @(negedge clk); eng_finish = 1'b0;
  endtask

  function automatic logic [63:0] pat(input int i, input int s);
    return 64'h0123_4567_89AB_CDEF ^ (64'(i + 1) * 64'h1F3D_5B79_9775_B3D1) ^ (64'(s) << 56);
  endfunction

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0]  d;
    logic [127:0] cur;
    rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
    cbc_sel = 1'b0; eng_start = 1'b0; eng_finish = 1'b0; eng_iv_final = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 iv", iv_value, '0);
    chk("R1 flags", {err_ctx, err_early}, '0);
    chk("R1 phase", {msg_busy, msg_done}, '0);
    chk("R1 rdata", host_rdata, '0);

    rd(2'd0, d);
    chk("R8 early data", d, '0);
    chk("R8 early flag", err_early, 1'b1);
    repeat (3) @(negedge clk);
    chk("R9 early sticky", err_early, 1'b1);
    rd(2'd2, d);
    chk("R9 status read", d, 64'h2);
    wr(2'd2, 64'h1);
    chk("R9 clear other bit keeps", err_early, 1'b1);
    wr(2'd2, 64'h2);
    chk("R9 early cleared", err_early, 1'b0);
    chk("R9 status write no side effect", iv_value, '0);

    wr(2'd0, 64'hDEAD_BEEF_0000_0001);
    chk("R4 ctx flag", err_ctx, 1'b1);
    chk("R4 iv unchanged", iv_value, '0);
    wr(2'd2, 64'h1);
    chk("R9 ctx cleared", err_ctx, 1'b0);

    cbc_sel = 1'b1;
    wr(2'd0, 64'h1111_2222_3333_4444);
    chk("R2 low half", iv_value, {64'h0, 64'h1111_2222_3333_4444});
    start_msg();
    chk("R5 refused half-loaded start", msg_busy, 1'b0);

    for (int i = 0; i < 8; i++) begin
      wr(2'd0, pat(i, 1));
      wr(2'd1, pat(i, 2));
      chk("R2 sweep", iv_value, {pat(i, 2), pat(i, 1)});
    end
    chk("R2 no ctx err", err_ctx, 1'b0);

    cbc_sel = 1'b0;
    start_msg();
    chk("R5 refused without cbc", msg_busy, 1'b0);
    cbc_sel = 1'b1;

    for (int m = 0; m < 4; m++) begin
      cur = iv_value;
      start_msg();
      chk("R5 accepted", {msg_busy, msg_done}, 2'b10);
      wr(2'd1, 64'hBAD0_BAD0_BAD0_BAD0);
      chk("R3 iv unchanged", iv_value, cur);
      chk("R3 ctx flag", err_ctx, 1'b1);
      rd(2'd1, d);
      chk("R8 read while busy", {d, 63'h0, err_early}, {64'h0, 63'h0, 1'b1});
      wr(2'd2, 64'h3);
      finish_msg({pat(m, 7), pat(m, 6)});
      chk("R6 value", iv_value, {pat(m, 7), pat(m, 6)});
      chk("R6 phase", {msg_busy, msg_done}, 2'b01);
      rd(2'd0, d);
      chk("R7 low read", d, pat(m, 6));
      rd(2'd1, d);
      chk("R7 high read", d, pat(m, 7));
      chk("R7 no early flag", err_early, 1'b0);
    end

    finish_msg({128{1'b1}});
    chk("R11 stray finish value", iv_value, {pat(3, 7), pat(3, 6)});
    chk("R11 stray finish phase", {msg_busy, msg_done}, 2'b01);

    wr(2'd0, 64'hAAAA_0000_5555_FFFF);
    wr(2'd1, 64'h0F0F_1234_F0F0_4321);
    chk("R2 restore after done", iv_value, {64'h0F0F_1234_F0F0_4321, 64'hAAAA_0000_5555_FFFF});
    chk("R2 restore legal", err_ctx, 1'b0);
    start_msg();
    chk("R10 done cleared", {msg_busy, msg_done}, 2'b10);
    finish_msg({pat(9, 1), pat(9, 2)});
    start_msg();
    rd(2'd0, d);
    chk("R10 early after restart", {d, 63'h0, err_early}, {64'h0, 63'h0, 1'b1});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule